// File: doc/BRIEF.md
# Event Timestamp Tagger with Hex-Text Serial Output

The block keeps a free-running timestamp that advances on every clock and watches a small group of input pins. When any pin goes from low to high, after a two-flop synchroniser, the block captures the timestamp and the state of all pins. It then sends one fixed-length text record through its own asynchronous serial transmitter. The record is twelve uppercase hex digits of timestamp, a space, two hex digits of pin state and a newline. Because the newline ends every record, a host can find record boundaries without any other framing.

Each character goes out as a 7-data-bit frame with no parity, so it takes nine bit periods. A whole record therefore holds the line for 144 bit periods. The block holds no queue. An event that arrives while a record is still on the line is thrown away and counted in a saturating counter, which is visible at the ports. With a 100 MHz clock, the timestamp has 10 ns resolution, and 115200 baud is reached with a bit period of 868 clocks. The bit period is a parameter.

Top module: `evt_tagger`

## Requirements
- R1: A synchronous reset clears the timestamp counter and the dropped-event counter, drives `tx` high, returns the transmitter to idle and holds `busy` low.
- R2: The timestamp counter reads the number of clocks since reset was released. Suppose a pin rises between clock edge n and edge n+1, where the counter reads n after edge n. The record then carries timestamp n+2, because the synchroniser has two stages.
- R3: Each record is exactly 16 characters, in this order. First come the 12 timestamp digits, most significant nibble first, each digit 0x30-0x39 for 0-9 or 0x41-0x46 for A-F. Then comes a space (0x20). Then come the two status digits, high nibble first, in the same encoding. Last comes a newline (0x0A).
- R4: Each character frame is one low start bit, then seven data bits least significant bit first, then one high stop bit. Each bit lasts BIT_CYCLES clocks, and the line idles high. The first digit '0' (0x30) therefore holds the line low for 5*BIT_CYCLES clocks.
- R5: Frames follow one another with no gap. From the falling edge of the first start bit to the clock on which `busy` falls is exactly 144*BIT_CYCLES clocks.
- R6: An event is a rising edge on any synchronised pin. The status field holds every synchronised pin at the capture clock, including pins that were already high. Pins that rise on the same clock produce one record.
- R7: A falling edge on a pin starts no record, and `busy` stays low.
- R8: `busy` is high from the clock after capture until the last stop bit ends. An event seen while `busy` is high changes neither the record in progress nor causes any later record.
- R9: Every discarded event adds one to `drop_cnt`, which stops at 2^DROP_W-1.
- R10: `tx` is high whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one timestamp count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| evt_pins | input | NPINS | Asynchronous event inputs |
| tx | output | 1 | Serial data line, idles high |
| busy | output | 1 | High while a record is being sent |
| drop_cnt | output | DROP_W | Saturating count of discarded events |

## Verification
The bench decodes the serial line itself and compares each record with one built from its own clock count. A design that got the synchroniser latency wrong, or that sent digits in the wrong nibble order, would therefore show a wrong timestamp. Several pins rising at once must give one record, and a pin that was already high must still appear in the status field; a design that kept only the rising pins would report the wrong status. Pulses on another pin during a record must raise the drop count up to its ceiling and then stop, and they must neither corrupt the record in progress nor start a late one. A design that buffered these events, or whose counter wrapped, would fail here. A reset in the middle of a record must leave the line high and the counters at zero. After that reset, timestamps must start again from the reset origin.

// File: rtl/evt_tagger_pkg.sv
package evt_tagger_pkg;

  localparam int CHAR_W = 7;
  localparam logic [CHAR_W-1:0] CH_SPACE   = 7'h20;
  localparam logic [CHAR_W-1:0] CH_NEWLINE = 7'h0A;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_STOP
  } tx_state_e;

  // Maps a nibble to its uppercase hex text code.
  function automatic logic [CHAR_W-1:0] hex_char(input logic [3:0] nib);
    logic [CHAR_W-1:0] wide;
    wide = {3'b000, nib};
    return (nib < 4'd10) ? wide + 7'h30 : wide + 7'h37;
  endfunction

endpackage

// File: rtl/evt_ts_counter.sv
module evt_ts_counter #(
  parameter int TS_W = 48
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts
);

  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= ts + 1'b1;
  end

endmodule

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_in,
  output logic [W-1:0] pins_sync,
  output logic         rise_any
);

  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], pins_in[i]};
    end
    assign pins_sync[i] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pins_sync;
  end

  assign rise_any = |(pins_sync & ~prev_q);

endmodule

// File: rtl/evt_msg_seq.sv
module evt_msg_seq
  import evt_tagger_pkg::*;
#(
  parameter int TS_W = 48,
  parameter int ST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TS_W-1:0]   ts_in,
  input  logic [ST_W-1:0]   st_in,
  input  logic              ch_ready,
  output logic              ch_valid,
  output logic [CHAR_W-1:0] ch_data,
  output logic              active
);

  localparam int TS_DIG  = (TS_W + 3) / 4;
  localparam int ST_DIG  = (ST_W + 3) / 4;
  localparam int NDIG    = TS_DIG + ST_DIG;
  localparam int MSG_LEN = NDIG + 2;
  localparam int IW      = $clog2(MSG_LEN);

  logic [NDIG*4-1:0] rec_q;
  logic [IW-1:0]     idx_q;
  logic              act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
    end else if (!act_q) begin
      if (start) begin
        rec_q <= {(TS_DIG*4)'(ts_in), (ST_DIG*4)'(st_in)};
        idx_q <= '0;
        act_q <= 1'b1;
      end
    end else if (ch_ready) begin
      if (idx_q == IW'(MSG_LEN - 1)) act_q <= 1'b0;
      else                           idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    int pos;
    int dig;
    logic [3:0] nib;
    pos = int'(idx_q);
    dig = (pos < TS_DIG) ? pos : pos - 1;
    if (dig > NDIG - 1) dig = NDIG - 1;
    nib = 4'(rec_q >> (4 * (NDIG - 1 - dig)));
    if (pos == TS_DIG)            ch_data = CH_SPACE;
    else if (pos == MSG_LEN - 1)  ch_data = CH_NEWLINE;
    else                          ch_data = hex_char(nib);
  end

  assign ch_valid = act_q;
  assign active   = act_q;

endmodule

// File: rtl/evt_uart7_tx.sv
module evt_uart7_tx
  import evt_tagger_pkg::*;
#(
  parameter int BIT_CYCLES = 868
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_valid,
  input  logic [CHAR_W-1:0] ch_data,
  output logic              ch_ready,
  output logic              tx,
  output logic              active
);

  localparam int CW = $clog2(BIT_CYCLES);
  localparam int BW = $clog2(CHAR_W);

  tx_state_e         state_q;
  logic [CW-1:0]     tmr_q;
  logic [BW-1:0]     bit_q;
  logic [CHAR_W-1:0] sh_q;
  logic              tx_q;
  logic              done;

  assign done     = (tmr_q == CW'(BIT_CYCLES - 1));
  assign ch_ready = (state_q == TX_IDLE) || (state_q == TX_STOP && done);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_IDLE;
      tmr_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      tx_q    <= 1'b1;
    end else begin
      case (state_q)
        TX_IDLE: begin
          tmr_q <= '0;
          if (ch_valid) begin
            sh_q    <= ch_data;
            tx_q    <= 1'b0;
            state_q <= TX_START;
          end
        end
        TX_START: begin
          if (done) begin
            tmr_q   <= '0;
            tx_q    <= sh_q[0];
            sh_q    <= sh_q >> 1;
            bit_q   <= '0;
            state_q <= TX_DATA;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        TX_DATA: begin
          if (done) begin
            tmr_q <= '0;
            if (bit_q == BW'(CHAR_W - 1)) begin
              tx_q    <= 1'b1;
              state_q <= TX_STOP;
            end else begin
              tx_q  <= sh_q[0];
              sh_q  <= sh_q >> 1;
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        TX_STOP: begin
          if (done) begin
            tmr_q <= '0;
            if (ch_valid) begin
              sh_q    <= ch_data;
              tx_q    <= 1'b0;
              state_q <= TX_START;
            end else begin
              state_q <= TX_IDLE;
            end
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign tx     = tx_q;
  assign active = (state_q != TX_IDLE);

endmodule

// File: rtl/evt_tagger.sv
module evt_tagger
  import evt_tagger_pkg::*;
#(
  parameter int TS_W        = 48,
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BIT_CYCLES  = 868,
  parameter int DROP_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  evt_pins,
  output logic              tx,
  output logic              busy,
  output logic [DROP_W-1:0] drop_cnt
);

  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic [TS_W-1:0]   ts;
  logic [NPINS-1:0]  pins_sync;
  logic              rise_any;
  logic              seq_active;
  logic              uart_active;
  logic              ch_valid;
  logic              ch_ready;
  logic [CHAR_W-1:0] ch_data;
  logic              busy_int;
  logic              start;
  logic [DROP_W-1:0] drop_q;

  evt_ts_counter #(.TS_W(TS_W)) u_ts (
    .clk (clk),
    .rst (rst),
    .ts  (ts)
  );

  evt_sync_edge #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pins_in   (evt_pins),
    .pins_sync (pins_sync),
    .rise_any  (rise_any)
  );

  assign busy_int = seq_active | uart_active;
  assign start    = rise_any & ~busy_int;

  evt_msg_seq #(.TS_W(TS_W), .ST_W(NPINS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ts_in    (ts),
    .st_in    (pins_sync),
    .ch_ready (ch_ready),
    .ch_valid (ch_valid),
    .ch_data  (ch_data),
    .active   (seq_active)
  );

  evt_uart7_tx #(.BIT_CYCLES(BIT_CYCLES)) u_uart (
    .clk      (clk),
    .rst      (rst),
    .ch_valid (ch_valid),
    .ch_data  (ch_data),
    .ch_ready (ch_ready),
    .tx       (tx),
    .active   (uart_active)
  );

  always_ff @(posedge clk) begin
    if (rst)                                        drop_q <= '0;
    else if (rise_any && busy_int && drop_q != DROP_MAX) drop_q <= drop_q + 1'b1;
  end

  assign busy     = busy_int;
  assign drop_cnt = drop_q;

endmodule

// File: rtl/evt_tagger_chk.sv
module evt_tagger_chk #(
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx,
  input logic              busy,
  input logic [DROP_W-1:0] drop_cnt
);

  localparam logic [DROP_W-1:0] DMAX = '1;

  // R1: one clock after a reset edge the line is idle and counters are zero
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (tx && !busy && drop_cnt == '0));

  // R10: the line never leaves the high level outside a record
  p_idle_line_high_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx);

  // R9: the drop count moves by zero or one per clock
  p_drop_step_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + 1'b1));

  // R9: once at its ceiling the drop count stays there
  p_drop_saturate_r9: assert property (@(posedge clk) disable iff (rst)
    (drop_cnt == DMAX) |=> (drop_cnt == DMAX));

  // R8: discards only happen while a record is on the line
  p_drop_only_busy_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_cnt == $past(drop_cnt) || $past(busy)));

endmodule

bind evt_tagger evt_tagger_chk #(.DROP_W(DROP_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx       (tx),
  .busy     (busy),
  .drop_cnt (drop_cnt)
);

// File: tb/test_evt_tagger.sv
module test_evt_tagger;

  localparam int BIT    = 8;
  localparam int DW     = 3;
  localparam int MSGCYC = 144 * BIT;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    pins = 8'h00;
  logic          tx;
  logic          busy;
  logic [DW-1:0] drop_cnt;

  int n_chk  = 0;
  int n_fail = 0;
  int ferr   = 0;
  longint cyc = 0;
  logic [6:0] rxq [$];
  logic [6:0] rx_c;
  logic [6:0] exp_msg [16];

  always #5 clk = ~clk;

  evt_tagger #(.BIT_CYCLES(BIT), .DROP_W(DW)) i_evt_tagger (
    .clk      (clk),
    .rst      (rst),
    .evt_pins (pins),
    .tx       (tx),
    .busy     (busy),
    .drop_cnt (drop_cnt)
  );

  // bench model of the timestamp: clocks since reset release
  always_ff @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // serial decoder sampling mid-bit on falling clock edges
  always begin
    @(negedge clk);
    if (!rst && tx === 1'b0) begin
      repeat (BIT / 2) @(negedge clk);
      if (tx !== 1'b0) ferr++;
      for (int b = 0; b < 7; b++) begin
        repeat (BIT) @(negedge clk);
        rx_c[b] = tx;
      end
      repeat (BIT) @(negedge clk);
      if (tx !== 1'b1) ferr++;
      rxq.push_back(rx_c);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill_exp(input longint ts, input logic [7:0] st);
    string hx;
    hx = "0123456789ABCDEF";
    for (int i = 0; i < 12; i++) exp_msg[i] = 7'(hx[(ts >> (4 * (11 - i))) & 15]);
    exp_msg[12] = 7'h20;
    exp_msg[13] = 7'(hx[st[7:4]]);
    exp_msg[14] = 7'(hx[st[3:0]]);
    exp_msg[15] = 7'h0A;
  endtask

  task automatic cmp_msg(input string req);
    int bad;
    bad = -1;
    chk(rxq.size() == 16, req, "record length", rxq.size(), 16);
    if (rxq.size() == 16)
      for (int i = 15; i >= 0; i--) if (rxq[i] != exp_msg[i]) bad = i;
    if (bad >= 0) chk(0, req, $sformatf("char %0d", bad), rxq[bad], exp_msg[bad]);
    else          chk(1, req, "record text", 0, 0);
    chk(ferr == 0, "R4", "frame errors", ferr, 0);
    rxq.delete();
  endtask

  // raise pins to pat and check the whole record that follows
  task automatic run_event(input logic [7:0] pat, input string req);
    longint t0;
    @(negedge clk);
    fill_exp(cyc + 2, pat);
    pins = pat;
    while (tx) @(negedge clk);
    t0 = cyc;
    while (!tx) @(negedge clk);
    chk(cyc - t0 == 5 * BIT, "R4", "first frame low time", cyc - t0, 5 * BIT);
    while (busy) @(negedge clk);
    chk(cyc - t0 == MSGCYC, "R5", "record duration", cyc - t0, MSGCYC);
    repeat (4) @(negedge clk);
    cmp_msg(req);
  endtask

  localparam logic [15:0] VEC [5] = '{16'h0301, 16'h11A5, 16'h05FF, 16'h2780, 16'h093C};

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(tx == 1'b1 && busy == 1'b0 && drop_cnt == '0, "R1", "reset state",
        {tx, busy, drop_cnt}, 5'b10000);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      repeat (VEC[i][15:8]) @(negedge clk);
      run_event(VEC[i][7:0], "R3");
      pins = 8'h00;
      repeat (30) @(negedge clk);
      chk(busy == 1'b0 && rxq.size() == 0, "R7", "falling edges start nothing",
          rxq.size() + busy, 0);
    end

    // R6: an already-high pin appears in the status of a later event
    run_event(8'h01, "R2");
    repeat (6) @(negedge clk);
    run_event(8'h11, "R6");
    pins = 8'h00;
    repeat (10) @(negedge clk);

    // R8 / R9: events during a record are discarded and counted
    begin
      longint t0;
      @(negedge clk);
      fill_exp(cyc + 2, 8'h02);
      pins = 8'h02;
      while (tx) @(negedge clk);
      t0 = cyc;
      for (int p = 0; p < 10; p++) begin
        pins = 8'h0A;
        repeat (4) @(negedge clk);
        pins = 8'h02;
        repeat (4) @(negedge clk);
        if (p == 2) chk(drop_cnt == 3'd3, "R9", "drop count after 3", drop_cnt, 3);
      end
      chk(drop_cnt == 3'd7, "R9", "drop count saturated", drop_cnt, 7);
      while (busy) @(negedge clk);
      chk(cyc - t0 == MSGCYC, "R5", "record duration with drops", cyc - t0, MSGCYC);
      repeat (4) @(negedge clk);
      cmp_msg("R8");
      repeat (2 * MSGCYC) @(negedge clk);
      chk(busy == 1'b0 && rxq.size() == 0, "R8", "no late record",
          rxq.size() + busy, 0);
    end

    // R1: reset in the middle of a record
    pins = 8'h00;
    repeat (10) @(negedge clk);
    pins = 8'h04;
    repeat (300) @(negedge clk);
    rst  = 1'b1;
    pins = 8'h00;
    repeat (3) @(negedge clk);
    chk(tx == 1'b1 && busy == 1'b0 && drop_cnt == '0, "R1", "mid-record reset",
        {tx, busy, drop_cnt}, 5'b10000);
    rst = 1'b0;
    repeat (12 * BIT) @(negedge clk);
    chk(tx == 1'b1 && busy == 1'b0, "R10", "line idle after reset", {tx, busy}, 2'b10);
    rxq.delete();
    ferr = 0;
    run_event(8'h40, "R2");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule